// File: doc/BRIEF.md
# MDIO Clause-22 Management Master

This block is a management-bus master for an external Ethernet PHY. Software sees three 32-bit registers on a small memory-mapped bus: a status word, a command word and a read-result word. One write to the command word queues a complete Clause-22 transaction. It holds a valid flag, the choice of read or write, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then serialises the frame on MDC/MDIO, and software goes on with other work.

Status carries two separate flags. The queued flag says that a command has been accepted but the shifter has not yet taken it. The in-flight flag says that a frame is on the wire. Software waits for the queued flag to clear before it issues another command, so writes are posted. It waits for the in-flight flag to clear before it reads back a result. A read result holds the 16 returned data bits and a two-bit failure field. That field is set when the PHY did not pull the second turnaround bit low. MDC comes from the system clock through a parameterised divider.

Top module: `mdio_master`

## Requirements
- R1: The bus offsets are 0x0 for status, 0x8 for command and 0xC for read result. Every other offset reads as zero. Status bit 2 is the queued flag and status bit 3 is the in-flight flag, and all other status bits read zero. The result word is {14'b0, fail[1:0], data[15:0]}. After reset the status word and the result word are both zero.
- R2: The command word is accepted only when all of these hold: bit 31 (valid) is set, exactly one of bit 1 (write) and bit 2 (read) is set, and the queued flag is clear. Its fields are write data in [19:4], register address in [24:20] and PHY address in [29:25].
- R3: A command word with bit 31 clear is ignored. A command word with bits 1 and 2 both set or both clear is also ignored. Ignored means that status stays zero, MDC does not toggle and MDIO is not driven.
- R4: A command written while the queued flag is set is ignored. No frame is ever sent for it. The queued flag stays set for as long as an earlier frame is in flight.
- R5: When the block is idle, the bus read in the cycle after an accepting write shows status 0x4 (queued only). The following cycle shows 0x8 (in flight only). A command queued behind a frame is taken in the cycle after that frame ends.
- R6: A write frame is sent in this order:
  - 32 ones;
  - the start pattern 01;
  - the opcode 01;
  - the PHY address, then the register address, each MSB first;
  - the turnaround 10;
  - the 16 data bits, MSB first.
  MDIO is driven for all 64 rising edges of MDC.
- R7: A read frame uses opcode 10. The master drives MDIO for the first 46 rising edges of MDC and releases it for the last 18. The 16 bits sampled on the last 16 rising edges appear in result bits 15:0.
- R8: If MDIO is high at the second turnaround bit of a read, result bits 17:16 read 11. Otherwise they read 00.
- R9: Each half period of MDC lasts DIV_HALF system clocks. MDIO output changes only on the falling edge of MDC. When idle, MDC is low and MDIO is not driven.
- R10: The in-flight flag stays set for exactly 128*DIV_HALF cycles per frame. When it clears, the read result has already been updated. A write frame leaves the result word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte offset |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, combinational from busAddr |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value to drive |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO pad value |

## Verification
Bus reads are combinational, so each result is checked in the cycle in which it is due:
- The queued flag is checked one cycle after the accepting write, and the in-flight flag one cycle after that.
- The in-flight flag is counted over exactly 128*DIV_HALF cycles.
- The result word is read in the first cycle in which the in-flight flag shows clear.

A PHY model in the bench samples MDIO on each MDC rising edge and decodes the frame from the preamble onward. For reads it changes its drive only after MDC falls. Written data is checked in the PHY model's register store, and returned data is checked through the result word. All sampling happens on the falling system-clock edge.

// File: rtl/mdiom_pkg.sv
package mdiom_pkg;
  localparam int BUS_W      = 32;
  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int RX_BITS    = 18;            // turnaround plus data, released on reads
  localparam int TA2_IDX    = 16;            // bit index of second turnaround bit
  localparam int PRE_BITS   = 32;

  typedef struct packed {
    logic load;      // take queued command into the shifter
    logic shift;     // advance to the next output bit (MDC falling)
    logic sample;    // capture MDIO (MDC rising)
    logic taSample;  // rising edge of second turnaround bit
    logic finish;    // frame complete
  } dpStrobe_t;
endpackage

// File: rtl/mdiom_ctrl.sv
module mdiom_ctrl
  import mdiom_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pending,
  input  logic      cmdRead,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      mdc,
  output logic      driveEn
);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);
  localparam logic [CNT_W-1:0] BIT_TOP  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] RX_FIRST = CNT_W'(RX_BITS);
  localparam logic [CNT_W-1:0] TA2_POS  = CNT_W'(TA2_IDX);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             frameRead;
  logic             halfTick;

  assign halfTick        = busy && (divCnt == DIV_LAST);
  assign strobe.load     = pending && !busy;
  assign strobe.sample   = halfTick && !mdc;
  assign strobe.taSample = halfTick && !mdc && (bitCnt == TA2_POS);
  assign strobe.shift    = halfTick && mdc && (bitCnt != '0);
  assign strobe.finish   = halfTick && mdc && (bitCnt == '0);
  assign driveEn         = busy && (!frameRead || (bitCnt >= RX_FIRST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      mdc       <= 1'b0;
      divCnt    <= '0;
      bitCnt    <= '0;
      frameRead <= 1'b0;
    end else if (strobe.load) begin
      busy      <= 1'b1;
      mdc       <= 1'b0;
      divCnt    <= '0;
      bitCnt    <= BIT_TOP;
      frameRead <= cmdRead;
    end else if (busy) begin
      divCnt <= halfTick ? '0 : divCnt + 1'b1;
      if (halfTick) mdc <= !mdc;
      if (strobe.shift) bitCnt <= bitCnt - 1'b1;
      if (strobe.finish) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mdiom_dp.sv
module mdiom_dp
  import mdiom_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  dpStrobe_t         strobe,
  input  logic              busy,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              pending,
  output logic              cmdRead
);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_RES  = ADDR_W'(12);

  logic [4:0]            cmdPhy, cmdReg;
  logic [15:0]           cmdData;
  logic [FRAME_BITS-1:0] shOut;
  logic [15:0]           shIn;
  logic [15:0]           resData;
  logic [1:0]            resFail;
  logic                  taFault;
  logic                  frameRead;
  logic                  accept;

  assign accept = busWrEn && (busAddr == OFF_CMD) && busWrData[31]
                  && (busWrData[1] ^ busWrData[2]) && !pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      cmdRead <= 1'b0;
      cmdPhy  <= '0;
      cmdReg  <= '0;
      cmdData <= '0;
    end else if (accept) begin
      pending <= 1'b1;
      cmdRead <= busWrData[2];
      cmdPhy  <= busWrData[29:25];
      cmdReg  <= busWrData[24:20];
      cmdData <= busWrData[19:4];
    end else if (strobe.load) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shOut     <= '1;
      shIn      <= '0;
      taFault   <= 1'b0;
      frameRead <= 1'b0;
      resData   <= '0;
      resFail   <= '0;
    end else begin
      if (strobe.load) begin
        shOut <= {{PRE_BITS{1'b1}}, 2'b01, cmdRead ? 2'b10 : 2'b01,
                  cmdPhy, cmdReg, 2'b10, cmdData};
        frameRead <= cmdRead;
      end else if (strobe.shift) begin
        shOut <= {shOut[FRAME_BITS-2:0], 1'b1};
      end
      if (strobe.sample) shIn <= {shIn[14:0], mdioIn};
      if (strobe.taSample) taFault <= mdioIn;
      if (strobe.finish && frameRead) begin
        resData <= shIn;
        resFail <= {2{taFault}};
      end
    end
  end

  assign mdioOut = busy ? shOut[FRAME_BITS-1] : 1'b1;

  always_comb begin
    unique case (busAddr)
      OFF_STAT: busRdData = {28'b0, busy, pending, 2'b00};
      OFF_RES:  busRdData = {14'b0, resFail, resData};
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdiom_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  dpStrobe_t strobe;
  logic      busy;
  logic      pending;
  logic      cmdRead;

  mdiom_ctrl #(.DIV_HALF(DIV_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .pending(pending), .cmdRead(cmdRead),
    .strobe(strobe), .busy(busy), .mdc(mdc), .driveEn(mdioOe)
  );

  mdiom_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .strobe(strobe),
    .busy(busy), .mdioIn(mdioIn), .mdioOut(mdioOut),
    .pending(pending), .cmdRead(cmdRead)
  );
endmodule

// File: rtl/mdiom_checker.sv
module mdiom_checker (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic busy,
  input logic pending
);
  assert_out_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && !$fell(mdc) |-> $stable(mdioOut));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc && !mdioOe);

  assert_release_on_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdioOe) |-> $fell(mdc));

  assert_queue_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    pending && busy |=> pending);

  assert_handover_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pending) |-> busy);

  assert_end_on_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $fell(mdc));
endmodule

bind mdio_master mdiom_checker u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut),
  .mdioOe(mdioOe), .busy(busy), .pending(pending)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int DIV_HALF = 2;
  localparam int FRAME_CYC = 128 * DIV_HALF;
  localparam logic [4:0] MODEL_PHY = 5'h03;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic mdc, mdioOut, mdioOe, mdioIn;
  logic phyDrv = 1'b1;

  assign mdioIn = mdioOe ? mdioOut : phyDrv;

  always #2 clk = !clk;

  mdio_master #(.DIV_HALF(DIV_HALF), .ADDR_W(4)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model
  logic [15:0] phyMem [32];
  int st = 0, ones = 0, n = 0;
  logic [11:0] hdr;
  logic [17:0] wb, rb;
  logic [1:0] wTa;
  int riseCnt = 0, oeRiseCnt = 0;

  always @(posedge mdc) begin
    riseCnt++;
    if (mdioOe) oeRiseCnt++;
    case (st)
      0: if (mdioIn) ones++; else begin if (ones >= 32) st = 1; ones = 0; end
      1: begin if (mdioIn) begin st = 2; n = 0; end else st = 0; end
      2: begin
        hdr = {hdr[10:0], mdioIn}; n++;
        if (n == 12) begin
          n = 0;
          if (hdr[11:10] == 2'b01) st = 3;
          else if (hdr[11:10] == 2'b10 && hdr[9:5] == MODEL_PHY) begin
            st = 4; rb = {2'b10, phyMem[hdr[4:0]]};
          end else st = 5;
        end
      end
      3: begin
        wb = {wb[16:0], mdioIn}; n++;
        if (n == 18) begin
          wTa = wb[17:16];
          if (hdr[9:5] == MODEL_PHY) phyMem[hdr[4:0]] = wb[15:0];
          st = 0;
        end
      end
      default: begin n++; if (n == 18) st = 0; end
    endcase
  end

  always @(negedge mdc) begin
    if (st == 4) begin phyDrv = rb[17]; rb = {rb[16:0], 1'b1}; end
    else phyDrv = 1'b1;
  end

  function automatic logic [31:0] cmdWord(input logic v, input logic rd, input logic wr,
                                          input logic [4:0] phy, input logic [4:0] ra,
                                          input logic [15:0] d);
    return {v, 1'b0, phy, ra, d, 1'b0, rd, wr, 1'b0};
  endfunction

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0; busAddr = 4'h0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a; #0.5; d = busRdData; busAddr = 4'h0;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      busRead(4'h0, s);
      if (s[3:2] == 2'b00) return;
      @(negedge clk);
    end
  endtask

  // fields: [28] read, [27:23] phy, [22:18] reg, [17:2] data, [1:0] fail
  localparam logic [28:0] VEC [7] = '{
    {1'b0, 5'h03, 5'd1,  16'hA5C3, 2'b00},
    {1'b0, 5'h03, 5'd31, 16'hFFFF, 2'b00},
    {1'b1, 5'h03, 5'd1,  16'hA5C3, 2'b00},
    {1'b1, 5'h03, 5'd31, 16'hFFFF, 2'b00},
    {1'b0, 5'h03, 5'd0,  16'h0001, 2'b00},
    {1'b1, 5'h03, 5'd0,  16'h0001, 2'b00},
    {1'b1, 5'h07, 5'd1,  16'hFFFF, 2'b11}
  };

  initial begin
    #800000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, r, lastRes;
    int cnt;
    for (int i = 0; i < 32; i++) phyMem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state and offsets
    busRead(4'h0, s); check("R1 status after reset", s, 32'h0);
    busRead(4'hC, s); check("R1 result after reset", s, 32'h0);
    busRead(4'h4, s); check("R1 unused offset", s, 32'h0);
    check("R9 idle pins", {30'b0, mdc, mdioOe}, 32'h0);

    // R5 handover timing and R10 frame length on a read
    @(negedge clk); busAddr = 4'h8;
    busWrData = cmdWord(1, 1, 0, MODEL_PHY, 5'd9, 16'h0); busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    busRead(4'h0, s); check("R5 queued one cycle after write", s, 32'h4);
    @(negedge clk);
    busRead(4'h0, s); check("R5 in flight next cycle", s, 32'h8);
    cnt = 1;
    forever begin
      @(negedge clk); busRead(4'h0, s);
      if (!s[3]) break;
      cnt++;
    end
    check("R10 in-flight length", cnt, FRAME_CYC);
    busRead(4'hC, s); check("R10 R7 result ready as flag clears", s, 32'h0);
    lastRes = 32'h0;

    // vector table: R2 R6 R7 R8 R10
    for (int v = 0; v < 7; v++) begin
      riseCnt = 0; oeRiseCnt = 0;
      busWrite(4'h8, cmdWord(1, VEC[v][28], !VEC[v][28], VEC[v][27:23], VEC[v][22:18], VEC[v][17:2]));
      @(negedge clk);
      waitIdle();
      check("R6 R7 rising edges per frame", riseCnt, 64);
      busRead(4'hC, r);
      if (VEC[v][28]) begin
        check("R7 driven edges on read", oeRiseCnt, 46);
        check("R7 R8 read result", r, {14'b0, VEC[v][1:0], VEC[v][17:2]});
        lastRes = r;
      end else begin
        check("R6 driven edges on write", oeRiseCnt, 64);
        check("R6 turnaround pattern", {30'b0, wTa}, 32'h2);
        check("R2 R6 PHY stored write data", {16'b0, phyMem[VEC[v][22:18]]}, {16'b0, VEC[v][17:2]});
        check("R10 write leaves result", r, lastRes);
      end
    end

    // R3 invalid commands ignored
    busWrite(4'h8, cmdWord(0, 0, 1, MODEL_PHY, 5'd5, 16'h1234));
    busWrite(4'h8, cmdWord(1, 1, 1, MODEL_PHY, 5'd6, 16'h1234));
    busWrite(4'h8, cmdWord(1, 0, 0, MODEL_PHY, 5'd7, 16'h1234));
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); busRead(4'h0, s);
      if (s != 0 || mdc || mdioOe) cnt++;
    end
    check("R3 invalid commands start nothing", cnt, 0);
    check("R3 no write reached PHY", {16'b0, phyMem[5]}, 32'h0);

    // R9 MDC half period
    busWrite(4'h8, cmdWord(1, 0, 1, MODEL_PHY, 5'd2, 16'h1111));
    while (!mdc) @(negedge clk);
    cnt = 0;
    while (mdc) begin @(negedge clk); cnt++; end
    check("R9 MDC high half period", cnt, DIV_HALF);
    cnt = 0;
    while (!mdc) begin @(negedge clk); cnt++; end
    check("R9 MDC low half period", cnt, DIV_HALF);

    // R4 queue behind a frame in flight, extra command dropped
    busWrite(4'h8, cmdWord(1, 0, 1, MODEL_PHY, 5'd3, 16'h2222));
    busRead(4'h0, s); check("R4 queued and in flight", s, 32'hC);
    busWrite(4'h8, cmdWord(1, 0, 1, MODEL_PHY, 5'd4, 16'h3333));
    busRead(4'h0, s); check("R4 still queued", s, 32'hC);
    waitIdle();
    check("R4 first frame delivered", {16'b0, phyMem[2]}, 32'h1111);
    check("R5 queued frame delivered", {16'b0, phyMem[3]}, 32'h2222);
    check("R4 command while queued dropped", {16'b0, phyMem[4]}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule